// File: doc/BRIEF.md
# Capture Field List Sequencer

This block turns one capture strobe into a short burst of 32-bit words. Software first fills a list of field descriptors, one write per entry. Each descriptor is a 10-bit code that names a source and, for a position channel, how to reduce it. After an arm strobe the block starts accumulating statistics for each position channel over the clocks where the gate input is high. On an accepted capture strobe it freezes the value of every listed field in that same cycle. It then presents the frozen words on `data_o`, one per clock and in list order, with `data_valid_o` high while they stream.

Sources are 32-bit position channels, a timestamp counter, a gated-sample count and a 128-bit bit bus. The bit bus is read as four 32-bit quadrants. If a capture arrives while the previous burst still has more than its final word left, the capture is dropped and a sticky health flag is raised. The next arm clears it. The statistics window restarts on every accepted capture, so back-to-back frames have no gap between them.

Top module: `capture_seq`

## Requirements
- R1: A descriptor holds the mode in bits [3:0] and the source index in bits [9:4]. Each write appends one descriptor to the end of the list. The list holds at most DEPTH entries, and writes made while it is full are ignored.
- R2: A clear strobe empties the list. A capture that arrives while the list is empty produces no output words.
- R3: An accepted capture with N listed descriptors drives `data_valid_o` high for exactly N consecutive cycles, starting in the cycle after the capture. The words appear in list order.
- R4: For an index below NPOS, the modes are 0 = value at the capture cycle, 1 = the sum over gated cycles of (value minus the previous clock's value), 2/3 = low/high word of the signed 64-bit sum of gated values, and 4/5 = signed minimum/maximum of gated values. Modes 4 and 5 give 0 when there were no gated samples. Every other mode gives 0.
- R5: A frame contains the gated cycles (gate high while armed) from the previous accepted capture or arm up to, but not including, the next accepted capture. A gated sample taken in a capture cycle counts toward the new frame.
- R6: The internal indexes are 0x20/0x21 start timestamp low/high, 0x22/0x23 end timestamp low/high, 0x24/0x25 capture timestamp low/high, 0x26 gated-sample count, and 0x27..0x2A bit-bus bits [31:0], [63:32], [95:64], [127:96]. Any other index, and any position index at or above NPOS, reads 0.
- R7: The timestamp counter is set to 0 by arm and advances by 1 each clock. The start timestamp is the counter value at the frame's first gated sample. The end timestamp is the value at the last gated sample plus 1. Both are 0 for a frame with no samples. The capture timestamp is the value in the capture cycle.
- R8: All words of a burst are fixed in the capture cycle. Input changes during the burst do not alter them.
- R9: A capture that arrives while a burst is running and not on its final word is dropped, and it sets `health_o` to 1. A capture exactly N cycles after the previous accepted one is accepted.
- R10: `health_o` is 0 after reset, stays at 1 once set, and returns to 0 only on arm.
- R11: Captures are ignored while disarmed. Disarm does not cut short a burst that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm strobe: start acquisition, clear timestamp, frame and health |
| disarm_i | input | 1 | Disarm strobe |
| cfg_wr_i | input | 1 | Append descriptor strobe |
| cfg_desc_i | input | 10 | Descriptor {index[5:0], mode[3:0]} |
| cfg_clr_i | input | 1 | Empty the descriptor list |
| gate_i | input | 1 | Sample-accept level |
| capture_i | input | 1 | Capture strobe, one cycle per event |
| pos_bus_i | input | NPOS*32 | Position channels, channel c at bits [32c+31:32c] |
| bit_bus_i | input | 128 | Bit bus |
| data_o | output | 32 | Current burst word, 0 when idle |
| data_valid_o | output | 1 | Burst word valid |
| health_o | output | 1 | Sticky too-close capture flag |

## Verification
The assertions assume that `capture_i` is a single-cycle strobe per event and that arm and disarm are pulses. They also assume that the descriptor list is not cleared and refilled in ways that depend on data already in flight, because a burst uses the length it latched at the capture. The stimulus drives every strobe for exactly one clock, between falling edges. It changes the list only while no burst is running, except in the snapshot and disarm cases, where it changes only bus inputs or the disarm strobe during the burst.

// File: rtl/capture_seq.sv
`timescale 1ns/1ps
module capture_seq #(
  parameter int NPOS  = 8,
  parameter int DEPTH = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              cfg_wr_i,
  input  logic [9:0]        cfg_desc_i,
  input  logic              cfg_clr_i,
  input  logic              gate_i,
  input  logic              capture_i,
  input  logic [NPOS*32-1:0] pos_bus_i,
  input  logic [127:0]      bit_bus_i,
  output logic [31:0]       data_o,
  output logic              data_valid_o,
  output logic              health_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          active, busy, health;
  logic [PW-1:0] ptr;
  logic [CW-1:0] len, blen;
  logic [9:0]    desc [DEPTH];
  logic [31:0]   snap [DEPTH];
  logic [63:0]   ts, ts_first, ts_last, ts_end;
  logic [31:0]   nsamp;
  logic [31:0]   cur  [NPOS];
  logic [31:0]   stp  [NPOS];
  logic [31:0]   prev [NPOS];
  logic [31:0]   dacc [NPOS];
  logic [31:0]   vmin [NPOS];
  logic [31:0]   vmax [NPOS];
  logic [63:0]   sacc [NPOS];
  logic          last, accept, too_close, smp, start;

  assign last      = busy && (CW'(ptr) == blen - CW'(1));
  assign accept    = capture_i && active && !arm_i && (!busy || last);
  assign too_close = capture_i && active && !arm_i && busy && !last;
  assign smp       = active && gate_i && !arm_i;
  assign start     = accept && (len != '0);
  assign ts_end    = (nsamp != '0) ? ts_last + 64'd1 : '0;

  always_comb
    for (int c = 0; c < NPOS; c++) begin
      cur[c] = pos_bus_i[c*32 +: 32];
      stp[c] = cur[c] - prev[c];
    end

  // descriptor list
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          len <= '0;
    else if (cfg_clr_i)                  len <= '0;
    else if (cfg_wr_i && len < CW'(DEPTH)) len <= len + CW'(1);

  always_ff @(posedge clk)
    if (cfg_wr_i && !cfg_clr_i && len < CW'(DEPTH)) desc[PW'(len)] <= cfg_desc_i;

  // arm state, timestamp, health
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      health <= 1'b0;
      ts     <= '0;
    end else begin
      ts <= arm_i ? '0 : ts + 64'd1;
      if (arm_i)         active <= 1'b1;
      else if (disarm_i) active <= 1'b0;
      if (arm_i)          health <= 1'b0;
      else if (too_close) health <= 1'b1;
    end

  // frame-wide sample count and timestamps
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nsamp <= '0; ts_first <= '0; ts_last <= '0;
    end else if (arm_i || accept) begin
      nsamp    <= smp ? 32'd1 : '0;
      ts_first <= smp ? ts : '0;
      ts_last  <= smp ? ts : '0;
    end else if (smp) begin
      nsamp   <= nsamp + 32'd1;
      ts_last <= ts;
      if (nsamp == '0) ts_first <= ts;
    end

  // per-channel statistics
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < NPOS; c++) begin
        prev[c] <= '0; dacc[c] <= '0; vmin[c] <= '0; vmax[c] <= '0; sacc[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NPOS; c++) begin
        prev[c] <= cur[c];
        if (arm_i || accept) begin
          sacc[c] <= smp ? {{32{cur[c][31]}}, cur[c]} : '0;
          dacc[c] <= smp ? stp[c] : '0;
          vmin[c] <= smp ? cur[c] : '0;
          vmax[c] <= smp ? cur[c] : '0;
        end else if (smp) begin
          sacc[c] <= sacc[c] + {{32{cur[c][31]}}, cur[c]};
          dacc[c] <= dacc[c] + stp[c];
          if (nsamp == '0 || $signed(cur[c]) < $signed(vmin[c])) vmin[c] <= cur[c];
          if (nsamp == '0 || $signed(cur[c]) > $signed(vmax[c])) vmax[c] <= cur[c];
        end
      end
    end

  function automatic logic [31:0] pick(input logic [9:0] d);
    logic [5:0]  ix;
    logic [3:0]  md;
    logic [31:0] r;
    ix = d[9:4];
    md = d[3:0];
    r  = '0;
    if (ix < 6'd32) begin
      for (int c = 0; c < NPOS; c++)
        if (ix == 6'(c))
          case (md)
            4'd0: r = cur[c];
            4'd1: r = dacc[c];
            4'd2: r = sacc[c][31:0];
            4'd3: r = sacc[c][63:32];
            4'd4: r = vmin[c];
            4'd5: r = vmax[c];
            default: r = '0;
          endcase
    end else begin
      case (ix)
        6'h20: r = ts_first[31:0];
        6'h21: r = ts_first[63:32];
        6'h22: r = ts_end[31:0];
        6'h23: r = ts_end[63:32];
        6'h24: r = ts[31:0];
        6'h25: r = ts[63:32];
        6'h26: r = nsamp;
        6'h27: r = bit_bus_i[31:0];
        6'h28: r = bit_bus_i[63:32];
        6'h29: r = bit_bus_i[95:64];
        6'h2A: r = bit_bus_i[127:96];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  logic [DEPTH-1:0][31:0] word;
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign word[i] = pick(desc[i]);
  end

  always_ff @(posedge clk)
    if (start)
      for (int i = 0; i < DEPTH; i++) snap[i] <= word[i];

  // serializer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; ptr <= '0; blen <= '0;
    end else if (start) begin
      busy <= 1'b1; ptr <= '0; blen <= len;
    end else if (last) begin
      busy <= 1'b0; ptr <= '0;
    end else if (busy) begin
      ptr <= ptr + PW'(1);
    end

  assign data_o       = busy ? snap[ptr] : '0;
  assign data_valid_o = busy;
  assign health_o     = health;

  // R3
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (CW'(ptr) < blen));
  // R3
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (data_valid_o && ptr == '0));
  // R9
  close_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (too_close && !arm_i) |=> health_o);
  // R10
  health_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (health_o && !arm_i) |=> health_o);
  // R10
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !health_o);
  // R2
  list_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr_i |=> (len == '0));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !data_valid_o) |=> !data_valid_o);
endmodule

// File: tb/sim_capture_seq.sv
`timescale 1ns/1ps
module sim_capture_seq;
  localparam int NPOS  = 8;
  localparam int DEPTH = 16;
  localparam int NV    = 25;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, arm_i, disarm_i, cfg_wr_i, cfg_clr_i, gate_i, capture_i;
  logic [9:0] cfg_desc_i;
  logic [NPOS*32-1:0] pos_bus_i;
  logic [127:0] bit_bus_i;
  logic [31:0] data_o;
  logic data_valid_o, health_o;
  logic [31:0] pos [NPOS];

  always_comb
    for (int c = 0; c < NPOS; c++) pos_bus_i[c*32 +: 32] = pos[c];

  capture_seq #(.NPOS(NPOS), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
    .cfg_wr_i(cfg_wr_i), .cfg_desc_i(cfg_desc_i), .cfg_clr_i(cfg_clr_i),
    .gate_i(gate_i), .capture_i(capture_i), .pos_bus_i(pos_bus_i),
    .bit_bus_i(bit_bus_i), .data_o(data_o), .data_valid_o(data_valid_o),
    .health_o(health_o));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // {descriptor, expected word} for the fixed frame built by run_frame
  localparam logic [41:0] VEC [NV] = '{
    {10'h010, 32'd30},        {10'h011, 32'hFFFF_FFF8}, {10'h012, 32'd34},
    {10'h013, 32'd0},         {10'h014, 32'd7},         {10'h015, 32'd15},
    {10'h017, 32'd0},         {10'h022, 32'hFFFF_FFF1}, {10'h023, 32'hFFFF_FFFF},
    {10'h024, 32'hFFFF_FFFB}, {10'h025, 32'hFFFF_FFFB}, {10'h032, 32'h5000_0000},
    {10'h033, 32'd1},         {10'h260, 32'd3},         {10'h200, 32'd1},
    {10'h220, 32'd5},         {10'h240, 32'd5},         {10'h250, 32'd0},
    {10'h270, 32'h1111_1111}, {10'h290, 32'h3333_3333}, {10'h2A0, 32'h4444_4444},
    {10'h090, 32'd0},         {10'h2B0, 32'd0},         {10'h210, 32'd0},
    {10'h230, 32'd0}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_list();
    cfg_clr_i = 1'b1; tick(); cfg_clr_i = 1'b0;
  endtask

  task automatic add(input logic [9:0] d);
    cfg_wr_i = 1'b1; cfg_desc_i = d; tick(); cfg_wr_i = 1'b0;
  endtask

  task automatic do_arm();
    arm_i = 1'b1; tick(); arm_i = 1'b0;
  endtask

  task automatic step(input logic g, input logic [31:0] p1, input logic cap);
    gate_i = g; pos[1] = p1; capture_i = cap; tick(); capture_i = 1'b0;
  endtask

  task automatic run_frame();
    gate_i = 1'b0; capture_i = 1'b0;
    do_arm();
    step(1'b0, 32'd10, 1'b0);
    step(1'b1, 32'd12, 1'b0);
    step(1'b1, 32'd15, 1'b0);
    step(1'b0, 32'd20, 1'b0);
    step(1'b1, 32'd7,  1'b0);
    step(1'b0, 32'd30, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; arm_i = 0; disarm_i = 0; cfg_wr_i = 0; cfg_clr_i = 0;
    gate_i = 0; capture_i = 0; cfg_desc_i = '0;
    for (int c = 0; c < NPOS; c++) pos[c] = '0;
    pos[2] = 32'hFFFF_FFFB;
    pos[3] = 32'h7000_0000;
    bit_bus_i = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R10 reset health", {31'd0, health_o}, 32'd0);
    chk("R3 reset valid", {31'd0, data_valid_o}, 32'd0);
    chk("R3 reset data", data_o, 32'd0);

    // R4 R5 R6 R7 table of single-field captures
    for (int k = 0; k < NV; k++) begin
      clear_list();
      add(VEC[k][41:32]);
      run_frame();
      chk($sformatf("R4 R6 R7 vector %0d", k), data_o, VEC[k][31:0]);
      chk($sformatf("R3 vector %0d valid", k), {31'd0, data_valid_o}, 32'd1);
      tick();
      chk($sformatf("R3 vector %0d end", k), {31'd0, data_valid_o}, 32'd0);
    end

    // R3 R8 order and snapshot
    clear_list(); add(10'h010); add(10'h290); add(10'h012);
    do_arm();
    step(1'b0, 32'd50, 1'b0);
    step(1'b0, 32'd50, 1'b1);
    chk("R3 word0", data_o, 32'd50);
    pos[1] = 32'd99; bit_bus_i = '0;
    tick(); chk("R8 word1 frozen", data_o, 32'h3333_3333);
    tick(); chk("R3 word2", data_o, 32'd0);
    chk("R3 word2 valid", {31'd0, data_valid_o}, 32'd1);
    tick(); chk("R3 burst length", {31'd0, data_valid_o}, 32'd0);
    bit_bus_i = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};

    // R9 spacing
    clear_list(); add(10'h010); add(10'h010); add(10'h010);
    do_arm();
    step(1'b0, 32'd1, 1'b1);
    tick(); tick();
    step(1'b0, 32'd2, 1'b1);
    chk("R9 spacing N accepted", data_o, 32'd2);
    chk("R9 no flag at N", {31'd0, health_o}, 32'd0);
    tick();
    step(1'b0, 32'd3, 1'b1);
    chk("R9 flag set", {31'd0, health_o}, 32'd1);
    chk("R9 dropped keeps burst", data_o, 32'd2);
    tick();
    chk("R9 dropped no burst", {31'd0, data_valid_o}, 32'd0);

    // R10 sticky
    repeat (3) tick();
    chk("R10 sticky", {31'd0, health_o}, 32'd1);
    do_arm();
    chk("R10 arm clears", {31'd0, health_o}, 32'd0);

    // R4 R7 empty frame
    clear_list(); add(10'h014); add(10'h015); add(10'h200); add(10'h220); add(10'h260);
    do_arm();
    step(1'b0, 32'd5, 1'b0);
    step(1'b0, 32'd5, 1'b1);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R4 R7 empty frame word %0d", k), data_o, 32'd0);
      tick();
    end

    // R11 disarm
    clear_list(); add(10'h010);
    do_arm();
    disarm_i = 1'b1; tick(); disarm_i = 1'b0;
    step(1'b0, 32'd4, 1'b1);
    chk("R11 disarmed capture ignored", {31'd0, data_valid_o}, 32'd0);
    clear_list(); add(10'h010); add(10'h010); add(10'h010);
    do_arm();
    step(1'b0, 32'd7, 1'b1);
    disarm_i = 1'b1; tick(); disarm_i = 1'b0;
    chk("R11 burst continues", data_o, 32'd7);
    chk("R11 burst valid", {31'd0, data_valid_o}, 32'd1);
    tick(); tick();
    chk("R11 burst ends", {31'd0, data_valid_o}, 32'd0);

    // R2 clear
    do_arm();
    clear_list();
    step(1'b0, 32'd8, 1'b1);
    chk("R2 empty list no words", {31'd0, data_valid_o}, 32'd0);

    // R1 capacity
    clear_list();
    for (int k = 0; k < DEPTH + 1; k++) add(10'h010);
    do_arm();
    step(1'b0, 32'd6, 1'b1);
    n = 0;
    for (int k = 0; k < DEPTH + 3; k++) begin
      if (data_valid_o) n++;
      tick();
    end
    chk("R1 list capacity", n, DEPTH);

    // R5 gap-less frames
    clear_list(); add(10'h260);
    do_arm();
    step(1'b1, 32'd1, 1'b0);
    step(1'b1, 32'd1, 1'b0);
    step(1'b1, 32'd1, 1'b0);
    step(1'b1, 32'd1, 1'b1);
    chk("R5 first frame", data_o, 32'd3);
    step(1'b1, 32'd1, 1'b0);
    step(1'b1, 32'd1, 1'b1);
    chk("R5 capture cycle joins next frame", data_o, 32'd2);
    gate_i = 1'b0;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule